// File: doc/BRIEF.md
# Four-Channel Linked-Descriptor DMA Engine

This block moves blocks of bytes from one address range to another over a single 32-bit memory port. Both ranges may sit in the same memory. There are four channels, and each one is set up through a small register bus. A channel runs in one of two modes. In direct mode, its source, destination and byte count come straight from its registers. In chained mode, the channel reads four-word descriptors from memory and runs them one after another until it reaches a descriptor marked as the last.

Source address, destination address and length may each have any byte alignment. Source words are read and shifted into place. Each destination word is written with byte enables set only for the lanes that carry copied bytes, so the bytes around the target range are never touched.

Busy channels share the memory port in round-robin order. A channel keeps the port until it has moved its programmed byte quota or its current segment ends. Each channel keeps four status bits. A single interrupt line combines those bits through per-channel enable bits.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, every channel's control and status read as zero, `mem_req` is low and `irq` is low.
- R2: Each channel has its own registers, selected by `reg_addr[4:3]`. The register is selected by `reg_addr[2:0]`: 0 = control, 1 = source, 2 = destination, 3 = byte count, 4 = next pointer, 5 = status. Writing control with bit 0 set starts the channel. When control bit 1 is clear, the channel copies `count` bytes from source to destination. When the copy ends, status bit 0 (busy) clears and status bits 1 (segment done) and 2 (chain done) are set.
- R3: Source, destination and count may have any alignment. Byte `a` of memory lives in lane `a[1:0]` of the word at `a & ~3`. Destination bytes outside the target range keep their values, and a write enables only the lanes it fills.
- R4: A count of zero completes the segment with no memory write and sets the done bits as in R2.
- R5: When control bit 1 is set, the next-pointer register holds the first descriptor address. A descriptor is four words at rising addresses: source, destination, count, next. Bit 0 of the next word marks the end of the chain. Each finished segment sets segment done. Chain done is set, and busy cleared, only after the marked descriptor finishes, and the next-pointer register then reads back that final next word.
- R6: Busy channels are served in round-robin order, starting after the channel served last. A grant ends once the bytes written in it reach the quota in control bits 15:8, or when the segment ends. A quota of 0 allows one word write per grant.
- R7: An error response (`mem_err` with `mem_gnt`) stops only the channel that owns the access. That channel clears busy, sets status bit 3 and makes no further writes, while the other channels complete normally.
- R8: Status bits 1 to 3 are cleared by writing 1 to them. Writing 0 has no effect, and writes cannot change the busy bit.
- R9: `irq` is high while any channel has segment done with control bit 2 set, chain done with control bit 3 set, or error with control bit 4 set.
- R10: While a channel is busy, its writes to control (start included) and to the source, destination, count and next-pointer registers are ignored.
- R11: A raised `mem_req` keeps its address until `mem_gnt`. A granted access completes in that same cycle, with `mem_rdata` and `mem_err` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Channel (4:3) and register (2:0) select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| mem_gnt | input | 1 | Access accepted and completed this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| mem_err | input | 1 | Error response, valid with grant |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench uses the default parameters: four channels and an 8-bit quota field. With four channels, the round-robin pointer can wrap across every slot, and the chained and error cases can run on channels other than 0. With an 8-bit quota, one grant can be as short as a single word (quota 4) or long enough to cover a whole 16-byte segment (quota 255), so both interleaved and back-to-back write orders appear. The memory model withholds grant one cycle in three. This keeps requests waiting, so the hold rule and every state of the sequencer are exercised under back-pressure.

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int NCH = 4,
  parameter int QW  = 8,
  localparam int CB = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [CB+2:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          irq
);
  typedef enum logic [2:0] {S_IDLE, S_DESC, S_RD0, S_RD1, S_WR} st_t;

  st_t st;
  logic [31:0]   src_q [NCH];
  logic [31:0]   dst_q [NCH];
  logic [31:0]   cnt_q [NCH];
  logic [31:0]   nxt_q [NCH];
  logic [QW+7:0] ctl_q [NCH];
  logic [NCH-1:0] busy, segd, chnd, errf, needd, eoc;
  logic [CB-1:0] cur, last, pick;
  logic [1:0]    dix;
  logic [QW:0]   used;
  logic [31:0]   w0, w1;

  wire [CB-1:0] wch = reg_addr[CB+2:3];
  wire [2:0]    wrg = reg_addr[2:0];
  wire [31:0] s = src_q[cur];
  wire [31:0] d = dst_q[cur];
  wire [31:0] r = cnt_q[cur];
  wire [31:0] np = nxt_q[cur];
  wire [QW-1:0] quota = ctl_q[cur][QW+7:8];
  wire chain = ctl_q[cur][1];

  wire [2:0] room  = 3'd4 - {1'b0, d[1:0]};
  wire [2:0] n     = (r < 32'(room)) ? r[2:0] : room;
  wire       split = ({1'b0, s[1:0]} + n) > 3'd4;
  wire [31:0] sh   = 32'({w1, w0} >> {s[1:0], 3'b000});
  wire [3:0]  bm   = 4'((5'd1 << n) - 5'd1);
  wire [QW:0] used_n = used + (QW+1)'(n);

  assign mem_req = (st == S_DESC) || (st == S_RD0 && r != 0) || (st == S_RD1) || (st == S_WR);
  assign mem_we  = (st == S_WR);
  assign mem_wdata = (st == S_WR) ? (sh << {d[1:0], 3'b000}) : 32'h0;
  assign mem_be  = (st == S_WR) ? (bm << d[1:0]) : (mem_req ? 4'hF : 4'h0);

  always_comb begin
    case (st)
      S_DESC:  mem_addr = {np[31:2], 2'b00} + {28'h0, dix, 2'b00};
      S_RD0:   mem_addr = {s[31:2], 2'b00};
      S_RD1:   mem_addr = {s[31:2], 2'b00} + 32'd4;
      S_WR:    mem_addr = {d[31:2], 2'b00};
      default: mem_addr = 32'h0;
    endcase
  end

  wire xfer  = mem_req & mem_gnt;
  wire ok    = xfer & ~mem_err;
  wire fault = xfer & mem_err;
  wire fin   = (st == S_RD0 && r == 0) || (st == S_WR && ok && r == 32'(n));

  always_comb begin
    pick = last;
    for (int i = NCH; i >= 1; i--)
      if (busy[CB'((int'(last) + i) % NCH)]) pick = CB'((int'(last) + i) % NCH);
  end

  always_comb begin
    irq = 1'b0;
    for (int i = 0; i < NCH; i++)
      irq = irq | (segd[i] & ctl_q[i][2]) | (chnd[i] & ctl_q[i][3]) | (errf[i] & ctl_q[i][4]);
  end

  always_comb begin
    case (wrg)
      3'd0:    reg_rdata = 32'(ctl_q[wch]);
      3'd1:    reg_rdata = src_q[wch];
      3'd2:    reg_rdata = dst_q[wch];
      3'd3:    reg_rdata = cnt_q[wch];
      3'd4:    reg_rdata = nxt_q[wch];
      3'd5:    reg_rdata = {28'h0, errf[wch], chnd[wch], segd[wch], busy[wch]};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; last <= CB'(NCH - 1); dix <= '0; used <= '0;
      w0 <= '0; w1 <= '0;
      busy <= '0; segd <= '0; chnd <= '0; errf <= '0; needd <= '0; eoc <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0; dst_q[i] <= '0; cnt_q[i] <= '0; nxt_q[i] <= '0; ctl_q[i] <= '0;
      end
    end else begin
      if (reg_we) begin
        case (wrg)
          3'd0: if (!busy[wch]) begin
            ctl_q[wch] <= {reg_wdata[QW+7:1], 1'b0};
            if (reg_wdata[0]) begin
              busy[wch] <= 1'b1; needd[wch] <= reg_wdata[1]; eoc[wch] <= 1'b0;
            end
          end
          3'd1: if (!busy[wch]) src_q[wch] <= reg_wdata;
          3'd2: if (!busy[wch]) dst_q[wch] <= reg_wdata;
          3'd3: if (!busy[wch]) cnt_q[wch] <= reg_wdata;
          3'd4: if (!busy[wch]) nxt_q[wch] <= reg_wdata;
          3'd5: begin
            segd[wch] <= segd[wch] & ~reg_wdata[1];
            chnd[wch] <= chnd[wch] & ~reg_wdata[2];
            errf[wch] <= errf[wch] & ~reg_wdata[3];
          end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (|busy) begin
          cur <= pick; last <= pick; used <= '0; dix <= '0;
          st <= needd[pick] ? S_DESC : S_RD0;
        end
        S_DESC: if (ok) begin
          dix <= dix + 2'd1;
          case (dix)
            2'd0: src_q[cur] <= mem_rdata;
            2'd1: dst_q[cur] <= mem_rdata;
            2'd2: cnt_q[cur] <= mem_rdata;
            default: begin
              nxt_q[cur] <= mem_rdata; eoc[cur] <= mem_rdata[0];
              needd[cur] <= 1'b0; st <= S_RD0;
            end
          endcase
        end
        S_RD0: if (ok) begin w0 <= mem_rdata; st <= split ? S_RD1 : S_WR; end
        S_RD1: if (ok) begin w1 <= mem_rdata; st <= S_WR; end
        S_WR: if (ok) begin
          src_q[cur] <= s + 32'(n); dst_q[cur] <= d + 32'(n); cnt_q[cur] <= r - 32'(n);
          used <= used_n;
          st <= (used_n >= {1'b0, quota}) ? S_IDLE : S_RD0;
        end
        default: st <= S_IDLE;
      endcase
      if (fault) begin
        busy[cur] <= 1'b0; errf[cur] <= 1'b1; st <= S_IDLE;
      end
      if (fin) begin
        segd[cur] <= 1'b1; st <= S_IDLE;
        if (chain && !eoc[cur]) needd[cur] <= 1'b1;
        else begin busy[cur] <= 1'b0; chnd[cur] <= 1'b1; end
      end
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  assert_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'h0));

  assert_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(cur));

  assert_quota_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (used == '0 || used < {1'b0, quota}));

  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((segd | chnd | errf) != '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[g]) |-> (chnd[g] || errf[g]));
  end
endmodule

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, reg_we, mem_req, mem_we, mem_gnt, mem_err, irq;
  logic [4:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  dma_chain_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .irq(irq));

  int errs = 0, checks = 0;
  logic [7:0] mb [0:2047];
  logic [1:0] scnt = 2'd0;
  always @(posedge clk) scnt <= (scnt == 2'd2) ? 2'd0 : scnt + 2'd1;

  wire [10:0] wa = {mem_addr[10:2], 2'b00};
  assign mem_gnt   = mem_req & (scnt != 2'd0);
  assign mem_err   = mem_addr[11];
  assign mem_rdata = {mb[wa + 11'd3], mb[wa + 11'd2], mb[wa + 11'd1], mb[wa]};

  always @(posedge clk)
    if (mem_req && mem_gnt && mem_we && !mem_err)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mb[wa + 11'(b)] = mem_wdata[8*b +: 8];

  logic log_clr = 1'b0;
  int wn = 0;
  logic [31:0] wlog [0:15];
  always @(posedge clk)
    if (log_clr) wn = 0;
    else if (mem_req && mem_gnt && mem_we) begin
      if (wn < 16) wlog[wn] = mem_addr;
      wn = wn + 1;
    end

  int hs_bad = 0;
  logic pend = 1'b0;
  logic [31:0] paddr = 32'h0;
  always @(posedge clk) begin
    if (rst_n === 1'b1 && pend && (!mem_req || mem_addr != paddr)) hs_bad = hs_bad + 1;
    pend  = (rst_n === 1'b1) && mem_req && !mem_gnt;
    paddr = mem_addr;
  end

  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{'h000, 'h410, 16}, '{'h001, 'h410, 13}, '{'h000, 'h413, 10}, '{'h006, 'h419, 17},
    '{'h003, 'h412, 1},  '{'h005, 'h41E, 3},  '{'h010, 'h430, 0},  '{'h007, 'h411, 64}};

  function automatic logic [7:0] pat(int a);
    return 8'(a * 13 + 5);
  endfunction

  task automatic chk(bit good, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!good) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int a = 0; a < 1024; a++) mb[a] = pat(a);
    for (int a = 1024; a < 2048; a++) mb[a] = 8'hEE;
  endtask

  task automatic put_word(int a, logic [31:0] w);
    for (int i = 0; i < 4; i++) mb[a + i] = w[8*i +: 8];
  endtask

  task automatic reg_wr(int ch, int rg, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {2'(ch), 3'(rg)}; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(int ch, int rg, output logic [31:0] v);
    @(negedge clk);
    reg_addr = {2'(ch), 3'(rg)};
    #1 v = reg_rdata;
  endtask

  task automatic wait_done(int ch);
    logic [31:0] v;
    for (int t = 0; t < 5000; t++) begin
      reg_rd(ch, 5, v);
      if (!v[0]) break;
    end
  endtask

  task automatic setup(int ch, int src, int dst, int len);
    reg_wr(ch, 1, 32'(src)); reg_wr(ch, 2, 32'(dst)); reg_wr(ch, 3, 32'(len));
  endtask

  task automatic chk_copy(string tag, int src, int dst, int len);
    int bad = -1;
    logic [7:0] a = 8'h0, e = 8'h0, ex;
    for (int k = -2; k < len + 2; k++) begin
      ex = (k >= 0 && k < len) ? pat(src + k) : 8'hEE;
      if (mb[dst + k] != ex && bad < 0) begin bad = k; a = mb[dst + k]; e = ex; end
    end
    chk(bad < 0, tag, 32'(a), 32'(e));
  endtask

  task automatic clr_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #1500000;
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit good;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    good = 1'b1;
    for (int c = 0; c < 4; c++) begin
      reg_rd(c, 5, v); if (v != 0) good = 1'b0;
      reg_rd(c, 0, v); if (v != 0) good = 1'b0;
    end
    chk(good && !mem_req && !irq, "R1 reset state", {30'h0, mem_req, irq}, 32'h0);

    // direct-mode table: R2 aligned, R3 unaligned, R4 zero length
    for (int i = 0; i < NV; i++) begin
      init_mem();
      clr_log();
      setup(0, VEC[i][0], VEC[i][1], VEC[i][2]);
      reg_wr(0, 0, 32'hFF01);
      wait_done(0);
      chk_copy(i == 0 ? "R2 aligned copy" : (VEC[i][2] == 0 ? "R4 zero copy" : "R3 unaligned copy"),
               VEC[i][0], VEC[i][1], VEC[i][2]);
      reg_rd(0, 5, v);
      chk(v == 32'h6, "R2 done status", v, 32'h6);
      if (VEC[i][2] == 0) chk(wn == 0, "R4 no writes", 32'(wn), 32'h0);
      if (i == 0) chk(irq == 1'b0, "R9 masked irq", 32'(irq), 32'h0);
      reg_wr(0, 5, 32'hE);
    end

    // R9 / R8
    init_mem();
    setup(0, 'h000, 'h410, 4);
    reg_wr(0, 0, 32'hFF05);
    wait_done(0);
    chk(irq == 1'b1, "R9 seg irq", 32'(irq), 32'h1);
    reg_wr(0, 5, 32'h2);
    reg_rd(0, 5, v);
    chk(v == 32'h4, "R8 clear seg", v, 32'h4);
    chk(irq == 1'b0, "R9 irq drop", 32'(irq), 32'h0);
    reg_wr(0, 5, 32'h0); reg_wr(0, 5, 32'h1);
    reg_rd(0, 5, v);
    chk(v == 32'h4, "R8 zero/busy write", v, 32'h4);
    reg_wr(0, 5, 32'h4);
    reg_rd(0, 5, v);
    chk(v == 32'h0, "R8 clear chain", v, 32'h0);

    // R6 quota 4: interleaved grants
    init_mem();
    setup(0, 'h000, 'h400, 16); setup(1, 'h100, 'h480, 16);
    clr_log();
    reg_wr(0, 0, 32'h0401); reg_wr(1, 0, 32'h0401);
    wait_done(0); wait_done(1);
    good = wlog[0] == 32'h400 && wlog[1] == 32'h480 && wlog[2] == 32'h404 && wlog[3] == 32'h484;
    chk(good, "R6 round robin quota 4", wlog[1], 32'h480);
    reg_wr(0, 5, 32'hE); reg_wr(1, 5, 32'hE);

    // R6 quota 255: whole segment per grant
    init_mem();
    setup(0, 'h000, 'h400, 16); setup(1, 'h100, 'h480, 16);
    clr_log();
    reg_wr(0, 0, 32'hFF01); reg_wr(1, 0, 32'hFF01);
    wait_done(0); wait_done(1);
    good = wlog[0] == 32'h400 && wlog[1] == 32'h404 && wlog[2] == 32'h408 && wlog[3] == 32'h40C
           && wlog[4] == 32'h480;
    chk(good, "R6 large quota", wlog[1], 32'h404);
    reg_wr(0, 5, 32'hE); reg_wr(1, 5, 32'hE);

    // R7 error isolates one channel
    init_mem();
    setup(1, 'h800, 'h600, 8); setup(3, 'h040, 'h640, 8);
    reg_wr(1, 0, 32'h0411); reg_wr(3, 0, 32'h0401);
    wait_done(1); wait_done(3);
    reg_rd(1, 5, v);
    chk(v == 32'h8, "R7 error status", v, 32'h8);
    chk_copy("R7 other channel", 'h040, 'h640, 8);
    good = 1'b1;
    for (int k = 0; k < 8; k++) if (mb['h600 + k] != 8'hEE) good = 1'b0;
    chk(good, "R7 no writes after error", 32'(mb['h600]), 32'hEE);
    chk(irq == 1'b1, "R9 error irq", 32'(irq), 32'h1);
    reg_wr(1, 5, 32'hE); reg_wr(3, 5, 32'hE);

    // R5 chained descriptors on channel 2
    init_mem();
    put_word('h380, 32'h020); put_word('h384, 32'h500); put_word('h388, 32'd7); put_word('h38C, 32'h390);
    put_word('h390, 32'h031); put_word('h394, 32'h521); put_word('h398, 32'd9); put_word('h39C, 32'h001);
    reg_wr(2, 4, 32'h380);
    reg_wr(2, 0, 32'hFF03);
    wait_done(2);
    chk_copy("R5 first segment", 'h020, 'h500, 7);
    chk_copy("R5 second segment", 'h031, 'h521, 9);
    reg_rd(2, 5, v);
    chk(v == 32'h6, "R5 chain status", v, 32'h6);
    reg_rd(2, 4, v);
    chk(v == 32'h1, "R5 final next word", v, 32'h1);
    reg_wr(2, 5, 32'hE);

    // R10 writes while busy ignored
    init_mem();
    setup(0, 'h000, 'h400, 64);
    reg_wr(0, 0, 32'h0401);
    reg_wr(0, 2, 32'h700); reg_wr(0, 3, 32'd4); reg_wr(0, 0, 32'h3);
    wait_done(0);
    chk_copy("R10 busy writes ignored", 'h000, 'h400, 64);
    good = 1'b1;
    for (int k = 0; k < 8; k++) if (mb['h700 + k] != 8'hEE) good = 1'b0;
    reg_rd(0, 5, v);
    chk(good && v == 32'h6, "R10 no redirect", v, 32'h6);

    // R11 request held until grant
    chk(hs_bad == 0, "R11 request hold", 32'(hs_bad), 32'h0);

    summary();
    $finish;
  end
endmodule